// File: doc/BRIEF.md
# Cross-Bus SRAM Guard and Show-Cycle Qualifier

This block sits at the bridge between a local bus and a second bus. The local bus owns an SRAM slave, and the second bus has masters of its own. A small control register holds a protection flag and a two-bit show-cycle mode, and both buses can write it.

While the protection flag is set, any second-bus access aimed at the local SRAM is refused. The block never selects the SRAM for such an access and instead returns a one-cycle data-error pulse. The second bus may write the protection flag only while the factory-test input is high. At other times its write leaves the flag as it was, and no error is raised. The mode field is always writable from either side.

The same register decides which local-bus cycles are mirrored to the external side as show cycles. Each qualifying cycle produces a one-cycle valid pulse carrying its address, data and direction. While protection is set, SRAM cycles are never mirrored.

Top module: `xbus_guard`

## Requirements
- R1: After reset the protection flag reads 0, the mode reads 00, and `sram_sel_o`, `sb_err_o` and `show_valid_o` are all low.
- R2: A local-bus register write always loads both the protection flag and the mode. The new values are visible on `cfg_prot_o`/`cfg_mode_o` in the cycle after the write edge.
- R3: A second-bus register write always loads the mode. It loads the protection flag only while `test_mode_i` is high; otherwise the flag keeps its value and `sb_err_o` stays low.
- R4: When both buses write the register in the same cycle, the local-bus values are loaded and the second-bus values are dropped.
- R5: A second-bus SRAM access (`sb_req_i` and `sb_sram_i` high) made while the flag is 1 raises `sb_err_o` for exactly one cycle after the sampling edge, and `sram_sel_o` stays low.
- R6: A second-bus SRAM access made while the flag is 0 raises `sram_sel_o` for one cycle after the sampling edge, with no error. A second-bus access that does not target the SRAM raises neither output.
- R7: Mode 01 mirrors local-bus write cycles only (`lb_we_i`=1) and never mirrors reads.
- R8: Mode 11 mirrors local-bus read and write cycles.
- R9: Mode 00 and the reserved mode 10 produce no show cycles.
- R10: While the flag is 1, local-bus cycles with `lb_sram_i` high are not mirrored, and cycles to other local-bus space still follow the mode.
- R11: A show pulse appears one cycle after the sampled local-bus cycle. During that pulse, `show_addr_o`, `show_data_o` and `show_we_o` carry that cycle's address, data and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_mode_i | input | 1 | Factory-test enable for second-bus flag writes |
| lb_wr_en_i | input | 1 | Local-bus register write strobe |
| lb_wr_prot_i | input | 1 | Local-bus write value for the protection flag |
| lb_wr_mode_i | input | 2 | Local-bus write value for the mode |
| sb_wr_en_i | input | 1 | Second-bus register write strobe |
| sb_wr_prot_i | input | 1 | Second-bus write value for the protection flag |
| sb_wr_mode_i | input | 2 | Second-bus write value for the mode |
| cfg_prot_o | output | 1 | Read-back of the protection flag |
| cfg_mode_o | output | 2 | Read-back of the mode |
| sb_req_i | input | 1 | Second-bus access request |
| sb_sram_i | input | 1 | Second-bus access targets the local SRAM |
| sram_sel_o | output | 1 | SRAM select for a granted second-bus access |
| sb_err_o | output | 1 | Data-error pulse for a refused access |
| lb_cyc_i | input | 1 | Local-bus cycle strobe |
| lb_we_i | input | 1 | Local-bus cycle is a write |
| lb_sram_i | input | 1 | Local-bus cycle targets the SRAM |
| lb_addr_i | input | AW | Local-bus address |
| lb_data_i | input | DW | Local-bus data |
| show_valid_o | output | 1 | Show-cycle pulse |
| show_we_o | output | 1 | Direction of the mirrored cycle |
| show_addr_o | output | AW | Address of the mirrored cycle |
| show_data_o | output | DW | Data of the mirrored cycle |

## Verification
The assertions assume that `sb_sram_i` and `lb_sram_i` matter only while their strobes are high, and that all inputs are stable around the clock edge. The bench changes every input on the falling edge and holds it through the rising edge. Each scenario returns the strobes to low before the next one starts, so every pulse can be traced to a single stimulus cycle. Same-cycle writes from both buses are applied on purpose, which exercises the local-priority rule that the assertions take for granted.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    // mode bit 0: mirroring enabled; bit 1: reads mirrored too
    typedef struct packed {
        logic       prot;
        logic [1:0] mode;
    } cfg_t;

    localparam int MODE_ON_BIT   = 0;
    localparam int MODE_READ_BIT = 1;
endpackage

// File: rtl/xbus_cfg_reg.sv
module xbus_cfg_reg
    import xbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       test_mode_i,
    input  logic       lb_wr_en_i,
    input  logic       lb_wr_prot_i,
    input  logic [1:0] lb_wr_mode_i,
    input  logic       sb_wr_en_i,
    input  logic       sb_wr_prot_i,
    input  logic [1:0] sb_wr_mode_i,
    output cfg_t       cfg_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (lb_wr_en_i) begin
            cfg_d.prot = lb_wr_prot_i;
            cfg_d.mode = lb_wr_mode_i;
        end else if (sb_wr_en_i) begin
            cfg_d.mode = sb_wr_mode_i;
            if (test_mode_i) begin
                cfg_d.prot = sb_wr_prot_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/xbus_sram_gate.sv
module xbus_sram_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic prot_i,
    input  logic req_i,
    input  logic sram_i,
    output logic sel_o,
    output logic err_o
);
    typedef struct packed {
        logic sel;
        logic err;
    } gate_t;

    gate_t gate_d, gate_q;
    logic  hit;

    always_comb begin
        hit        = req_i && sram_i;
        gate_d.sel = hit && !prot_i;
        gate_d.err = hit && prot_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign sel_o = gate_q.sel;
    assign err_o = gate_q.err;
endmodule

// File: rtl/xbus_show_qual.sv
module xbus_show_qual
    import xbus_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cfg_t          cfg_i,
    input  logic          cyc_i,
    input  logic          we_i,
    input  logic          sram_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic          valid_o,
    output logic          we_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o
);
    typedef struct packed {
        logic          valid;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } show_t;

    show_t show_d, show_q;
    logic  dir_ok;
    logic  masked;

    always_comb begin
        dir_ok       = cfg_i.mode[MODE_ON_BIT] && (we_i || cfg_i.mode[MODE_READ_BIT]);
        masked       = cfg_i.prot && sram_i;
        show_d       = show_q;
        show_d.valid = cyc_i && dir_ok && !masked;
        if (show_d.valid) begin
            show_d.we   = we_i;
            show_d.addr = addr_i;
            show_d.data = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            show_q <= '0;
        end else begin
            show_q <= show_d;
        end
    end

    assign valid_o = show_q.valid;
    assign we_o    = show_q.we;
    assign addr_o  = show_q.addr;
    assign data_o  = show_q.data;
endmodule

// File: rtl/xbus_guard.sv
module xbus_guard
    import xbus_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          test_mode_i,
    input  logic          lb_wr_en_i,
    input  logic          lb_wr_prot_i,
    input  logic [1:0]    lb_wr_mode_i,
    input  logic          sb_wr_en_i,
    input  logic          sb_wr_prot_i,
    input  logic [1:0]    sb_wr_mode_i,
    output logic          cfg_prot_o,
    output logic [1:0]    cfg_mode_o,
    input  logic          sb_req_i,
    input  logic          sb_sram_i,
    output logic          sram_sel_o,
    output logic          sb_err_o,
    input  logic          lb_cyc_i,
    input  logic          lb_we_i,
    input  logic          lb_sram_i,
    input  logic [AW-1:0] lb_addr_i,
    input  logic [DW-1:0] lb_data_i,
    output logic          show_valid_o,
    output logic          show_we_o,
    output logic [AW-1:0] show_addr_o,
    output logic [DW-1:0] show_data_o
);
    cfg_t cfg;

    xbus_cfg_reg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .test_mode_i  (test_mode_i),
        .lb_wr_en_i   (lb_wr_en_i),
        .lb_wr_prot_i (lb_wr_prot_i),
        .lb_wr_mode_i (lb_wr_mode_i),
        .sb_wr_en_i   (sb_wr_en_i),
        .sb_wr_prot_i (sb_wr_prot_i),
        .sb_wr_mode_i (sb_wr_mode_i),
        .cfg_o        (cfg)
    );

    xbus_sram_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .prot_i (cfg.prot),
        .req_i  (sb_req_i),
        .sram_i (sb_sram_i),
        .sel_o  (sram_sel_o),
        .err_o  (sb_err_o)
    );

    xbus_show_qual #(.AW(AW), .DW(DW)) u_show (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_i   (cfg),
        .cyc_i   (lb_cyc_i),
        .we_i    (lb_we_i),
        .sram_i  (lb_sram_i),
        .addr_i  (lb_addr_i),
        .data_i  (lb_data_i),
        .valid_o (show_valid_o),
        .we_o    (show_we_o),
        .addr_o  (show_addr_o),
        .data_o  (show_data_o)
    );

    assign cfg_prot_o = cfg.prot;
    assign cfg_mode_o = cfg.mode;
endmodule

// File: rtl/xbus_guard_chk.sv
module xbus_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       test_mode_i,
    input logic       lb_wr_en_i,
    input logic       lb_wr_prot_i,
    input logic [1:0] lb_wr_mode_i,
    input logic       sb_wr_en_i,
    input logic       cfg_prot_o,
    input logic [1:0] cfg_mode_o,
    input logic       sb_req_i,
    input logic       sb_sram_i,
    input logic       sram_sel_o,
    input logic       sb_err_o,
    input logic       lb_cyc_i,
    input logic       lb_sram_i,
    input logic       show_valid_o
);
    // R2
    lb_write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lb_wr_en_i |=> (cfg_prot_o == $past(lb_wr_prot_i)) && (cfg_mode_o == $past(lb_wr_mode_i)));

    // R3
    sb_prot_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_wr_en_i && !test_mode_i && !lb_wr_en_i) |=> $stable(cfg_prot_o));

    // R5
    refused_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_req_i && sb_sram_i && cfg_prot_o) |=> (sb_err_o && !sram_sel_o));

    // R5
    sel_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sb_err_o && sram_sel_o));

    // R6
    no_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sb_req_i && sb_sram_i) |=> (!sb_err_o && !sram_sel_o));

    // R9
    mode_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode_o[0] |=> !show_valid_o);

    // R10
    sram_show_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_cyc_i && lb_sram_i && cfg_prot_o) |=> !show_valid_o);
endmodule

bind xbus_guard xbus_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .test_mode_i  (test_mode_i),
    .lb_wr_en_i   (lb_wr_en_i),
    .lb_wr_prot_i (lb_wr_prot_i),
    .lb_wr_mode_i (lb_wr_mode_i),
    .sb_wr_en_i   (sb_wr_en_i),
    .cfg_prot_o   (cfg_prot_o),
    .cfg_mode_o   (cfg_mode_o),
    .sb_req_i     (sb_req_i),
    .sb_sram_i    (sb_sram_i),
    .sram_sel_o   (sram_sel_o),
    .sb_err_o     (sb_err_o),
    .lb_cyc_i     (lb_cyc_i),
    .lb_sram_i    (lb_sram_i),
    .show_valid_o (show_valid_o)
);

// File: tb/xbus_guard_tb.sv
module xbus_guard_tb;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_mode_i = 1'b0;
    logic          lb_wr_en_i = 1'b0, lb_wr_prot_i = 1'b0;
    logic [1:0]    lb_wr_mode_i = 2'b00;
    logic          sb_wr_en_i = 1'b0, sb_wr_prot_i = 1'b0;
    logic [1:0]    sb_wr_mode_i = 2'b00;
    logic          cfg_prot_o;
    logic [1:0]    cfg_mode_o;
    logic          sb_req_i = 1'b0, sb_sram_i = 1'b0;
    logic          sram_sel_o, sb_err_o;
    logic          lb_cyc_i = 1'b0, lb_we_i = 1'b0, lb_sram_i = 1'b0;
    logic [AW-1:0] lb_addr_i = '0;
    logic [DW-1:0] lb_data_i = '0;
    logic          show_valid_o, show_we_o;
    logic [AW-1:0] show_addr_o;
    logic [DW-1:0] show_data_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    xbus_guard #(.AW(AW), .DW(DW)) u_dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one active cycle: inputs set at negedge, outputs sampled just after posedge
    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic idle;
        @(negedge clk);
        lb_wr_en_i = 0; sb_wr_en_i = 0; sb_req_i = 0; lb_cyc_i = 0;
    endtask

    task automatic lb_write(input logic p, input logic [1:0] m);
        @(negedge clk);
        lb_wr_en_i = 1; lb_wr_prot_i = p; lb_wr_mode_i = m;
        step();
        idle();
    endtask

    task automatic t_reset;
        chk("R1 prot", cfg_prot_o, 0);
        chk("R1 mode", cfg_mode_o, 0);
        chk("R1 sel", sram_sel_o, 0);
        chk("R1 err", sb_err_o, 0);
        chk("R1 show", show_valid_o, 0);
    endtask

    task automatic t_local_write;
        lb_write(1, 2'b11);
        chk("R2 prot set", cfg_prot_o, 1);
        chk("R2 mode set", cfg_mode_o, 2'b11);
        lb_write(0, 2'b01);
        chk("R2 prot clr", cfg_prot_o, 0);
        chk("R2 mode 01", cfg_mode_o, 2'b01);
    endtask

    task automatic t_sb_write;
        @(negedge clk);
        test_mode_i = 0; sb_wr_en_i = 1; sb_wr_prot_i = 1; sb_wr_mode_i = 2'b11;
        step();
        chk("R3 locked prot", cfg_prot_o, 0);
        chk("R3 mode taken", cfg_mode_o, 2'b11);
        chk("R3 no err", sb_err_o, 0);
        @(negedge clk);
        test_mode_i = 1;
        step();
        chk("R3 test prot", cfg_prot_o, 1);
        idle();
        @(negedge clk);
        test_mode_i = 1; sb_wr_en_i = 1; sb_wr_prot_i = 0; sb_wr_mode_i = 2'b00;
        step();
        chk("R3 test clr", cfg_prot_o, 0);
        idle();
        test_mode_i = 0;
    endtask

    task automatic t_collision;
        @(negedge clk);
        test_mode_i = 1;
        lb_wr_en_i = 1; lb_wr_prot_i = 0; lb_wr_mode_i = 2'b01;
        sb_wr_en_i = 1; sb_wr_prot_i = 1; sb_wr_mode_i = 2'b11;
        step();
        chk("R4 prot local", cfg_prot_o, 0);
        chk("R4 mode local", cfg_mode_o, 2'b01);
        idle();
        test_mode_i = 0;
    endtask

    task automatic sb_access(input logic sram, input logic e_sel, input logic e_err, input string req);
        @(negedge clk);
        sb_req_i = 1; sb_sram_i = sram;
        step();
        chk({req, " sel"}, sram_sel_o, e_sel);
        chk({req, " err"}, sb_err_o, e_err);
        idle();
        step();
        chk({req, " err one cycle"}, sb_err_o, 0);
    endtask

    task automatic t_gate;
        lb_write(0, 2'b00);
        sb_access(1, 1, 0, "R6 open sram");
        sb_access(0, 0, 0, "R6 non-sram");
        lb_write(1, 2'b00);
        sb_access(1, 0, 1, "R5 blocked");
        sb_access(0, 0, 0, "R6 non-sram prot");
    endtask

    task automatic lb_cycle(input logic we, input logic sram, input logic [31:0] a,
                            input logic [31:0] d, input logic exp_v, input string req);
        @(negedge clk);
        lb_cyc_i = 1; lb_we_i = we; lb_sram_i = sram; lb_addr_i = a; lb_data_i = d;
        step();
        chk({req, " valid"}, show_valid_o, exp_v);
        if (exp_v) begin
            chk("R11 addr", show_addr_o, a);
            chk("R11 data", show_data_o, d);
            chk("R11 dir", show_we_o, we);
        end
        idle();
        step();
        chk({req, " pulse ends"}, show_valid_o, 0);
    endtask

    task automatic t_show;
        lb_write(0, 2'b01);
        lb_cycle(1, 0, 32'h1000_0004, 32'hCAFE_0001, 1, "R7 write");
        lb_cycle(0, 0, 32'h1000_0008, 32'hCAFE_0002, 0, "R7 read");
        lb_write(0, 2'b11);
        lb_cycle(0, 1, 32'h2000_0010, 32'hBEEF_0003, 1, "R8 read");
        lb_cycle(1, 1, 32'h2000_0014, 32'hBEEF_0004, 1, "R8 write");
        lb_write(0, 2'b00);
        lb_cycle(1, 0, 32'h3000_0000, 32'h1, 0, "R9 mode00");
        lb_write(0, 2'b10);
        lb_cycle(1, 0, 32'h3000_0004, 32'h2, 0, "R9 mode10 w");
        lb_cycle(0, 0, 32'h3000_0008, 32'h3, 0, "R9 mode10 r");
        lb_write(1, 2'b11);
        lb_cycle(1, 1, 32'h4000_0000, 32'h5, 0, "R10 sram masked");
        lb_cycle(0, 0, 32'h4000_0100, 32'h6, 1, "R10 other shown");
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        t_reset();
        t_local_write();
        t_sb_write();
        t_collision();
        t_gate();
        t_show();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule